// File: doc/BRIEF.md
# Channel Slave Decode Front End

This block sits at the bus edge of a memory or I/O adapter card on a shared channel. It watches the unlatched address, the memory/I-O select, the enable that marks a low (24-bit) address, and the refresh line. From these inputs it decides, without any register in the path, whether this card is being addressed. While the decode holds, it answers at once with an active-low card-selected acknowledge and with data-size feedback that matches the configured port width. It also slows the master down through a ready output for a fixed number of wait states.

The block captures the address offset and the cycle type in a register that tracks the bus while the address-decode strobe is low. The register freezes when that strobe rises or when the command strobe falls. From the captured state it produces local register strobes. A write gives a one-cycle enable at the leading edge of the command. A read gives a read enable for as long as the command is active, plus an output enable that lasts one cycle longer. Offsets at the top of the window are treated as destructive reads, and they never decode during a refresh. A diagnostic configuration input silences the card-selected acknowledge.

Top module: `chan_slave_front`

## Requirements
- R1: The decode hits when the select matches the space set by MEM_SPACE (default memory, `mio_i`=1) and the effective address bits above BLK_BITS equal `cfg_base_i`. With `mio_i`=0 and the default configuration, nothing decodes.
- R2: While `addr24_n_i` is low, address bits 24 and above are treated as zero. While it is high, the full address takes part in the decode, so a window above 16 MB only decodes with `addr24_n_i` high.
- R3: `sel_fb_n_o` is low in the same cycle as a hit, with no clock edge between the address and the acknowledge.
- R4: Width code `cfg_width_i`: 0 is an 8-bit port and drives neither size line. 1 is a 16-bit port and drives `size16_n_o` low. 2 or 3 is a 32-bit port and drives both `size16_n_o` and `size32_n_o` low.
- R5: When the address moves off the window, all three feedback lines return high at once.
- R6: While `refresh_n_i` is low, offsets at or above DESTR_FIRST (default 12) do not decode. Lower offsets still do.
- R7: `reg_addr_o` shows the low BLK_BITS address bits captured at clock edges where `adl_n_i` is low and `cmd_n_i` is high. It holds that value while `cmd_n_i` is low, even if the address changes.
- R8: Status is valid when `s0_n_i` or `s1_n_i` is low. `ready_o` goes low only while the decode hits with valid status. It rises after exactly WAIT_STATES (default 3) clock edges.
- R9: A captured write (`s0_n_i`=0, `s1_n_i`=1) with a captured hit gives `reg_wr_o` high for exactly one cycle, starting where `cmd_n_i` falls.
- R10: A captured read (`s0_n_i`=1, `s1_n_i`=0) with a captured hit holds `reg_rd_o` high while `cmd_n_i` is low. `rd_oe_o` stays high for one cycle after `cmd_n_i` rises.
- R11: With `cfg_diag_i` high, `sel_fb_n_o` stays high, while the size feedback still follows the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW | Unlatched bus address |
| mio_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| addr24_n_i | input | 1 | Low = address limited to 24 bits |
| refresh_n_i | input | 1 | Low = refresh in progress |
| s0_n_i | input | 1 | Status, low = write |
| s1_n_i | input | 1 | Status, low = read |
| adl_n_i | input | 1 | Address-decode strobe, active low |
| cmd_n_i | input | 1 | Command strobe, active low |
| cfg_base_i | input | AW-BLK_BITS | Window base, upper address bits |
| cfg_width_i | input | 2 | Port width code |
| cfg_diag_i | input | 1 | Diagnostic mode, silences acknowledge |
| sel_fb_n_o | output | 1 | Card-selected acknowledge, active low |
| size16_n_o | output | 1 | 16-bit size feedback, active low |
| size32_n_o | output | 1 | 32-bit size feedback, active low |
| ready_o | output | 1 | Channel ready, low stretches the cycle |
| reg_addr_o | output | BLK_BITS | Captured register offset |
| reg_rd_o | output | 1 | Register read enable |
| reg_wr_o | output | 1 | Register write pulse |
| rd_oe_o | output | 1 | Read data output enable |

## Verification
A bad decode shows at the feedback pins in the same cycle the address settles, because no register lies on that path. A wrong capture register shows later. It appears as a wrong `reg_addr_o` or a missing or extra strobe on the first command edge after the address-decode strobe closes. A wrong wait counter moves the rising edge of `ready_o` by one or more cycles, measured from status becoming valid. A stale read enable shows as `rd_oe_o` staying high past the cycle that follows the command's trailing edge.

// File: rtl/chan_slave_front.sv
module chan_slave_front #(
  parameter int AW          = 32,
  parameter int BLK_BITS    = 4,
  parameter int DESTR_FIRST = 12,
  parameter int WAIT_STATES = 3,
  parameter bit MEM_SPACE   = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          addr_i,
  input  logic                   mio_i,
  input  logic                   addr24_n_i,
  input  logic                   refresh_n_i,
  input  logic                   s0_n_i,
  input  logic                   s1_n_i,
  input  logic                   adl_n_i,
  input  logic                   cmd_n_i,
  input  logic [AW-BLK_BITS-1:0] cfg_base_i,
  input  logic [1:0]             cfg_width_i,
  input  logic                   cfg_diag_i,
  output logic                   sel_fb_n_o,
  output logic                   size16_n_o,
  output logic                   size32_n_o,
  output logic                   ready_o,
  output logic [BLK_BITS-1:0]    reg_addr_o,
  output logic                   reg_rd_o,
  output logic                   reg_wr_o,
  output logic                   rd_oe_o
);

  localparam int CW = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;

  logic [AW-1:0]       eff_addr;
  logic [BLK_BITS-1:0] ofs;
  logic                space_ok, destr, hit, st_valid, wait_done;
  logic                lat_open, lat_hit, lat_wr, lat_rd, lat_ref;
  logic [BLK_BITS-1:0] lat_ofs;
  logic [CW-1:0]       cnt;
  logic                cmd_q, rd_q;

  assign eff_addr = addr24_n_i ? addr_i : {{(AW-24){1'b0}}, addr_i[23:0]};
  assign ofs      = eff_addr[BLK_BITS-1:0];
  assign space_ok = MEM_SPACE ? mio_i : !mio_i;
  assign destr    = 32'(ofs) >= DESTR_FIRST;
  assign hit      = space_ok && (eff_addr[AW-1:BLK_BITS] == cfg_base_i) && !(destr && !refresh_n_i);

  assign sel_fb_n_o = !(hit && !cfg_diag_i);
  assign size16_n_o = !(hit && cfg_width_i != 2'd0);
  assign size32_n_o = !(hit && cfg_width_i[1]);

  assign st_valid  = !(s0_n_i && s1_n_i);
  assign wait_done = (cnt == CW'(WAIT_STATES));
  assign ready_o   = !(hit && st_valid && !wait_done);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 cnt <= '0;
    else if (!(hit && st_valid)) cnt <= '0;
    else if (!wait_done)        cnt <= cnt + 1'b1;

  assign lat_open = !adl_n_i && cmd_n_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lat_hit <= 1'b0;
      lat_wr  <= 1'b0;
      lat_rd  <= 1'b0;
      lat_ref <= 1'b0;
      lat_ofs <= '0;
    end else if (lat_open) begin
      lat_hit <= hit;
      lat_wr  <= !s0_n_i && s1_n_i;
      lat_rd  <= s0_n_i && !s1_n_i;
      lat_ref <= !refresh_n_i;
      lat_ofs <= ofs;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_q <= 1'b1;
      rd_q  <= 1'b0;
    end else begin
      cmd_q <= cmd_n_i;
      rd_q  <= reg_rd_o;
    end

  assign reg_addr_o = lat_ofs;
  assign reg_wr_o   = !cmd_n_i && cmd_q && lat_hit && lat_wr;
  assign reg_rd_o   = !cmd_n_i && lat_hit && lat_rd;
  assign rd_oe_o    = reg_rd_o || rd_q;

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o); // R9
  AST_RD_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rd_o) |-> rd_oe_o); // R10
  AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_n_i && $past(!cmd_n_i)) |-> $stable(lat_ofs)); // R7
  AST_NO_DESTR_ON_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rd_o || reg_wr_o) && lat_ref) |-> (32'(lat_ofs) < DESTR_FIRST)); // R6
  AST_SIZE_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    !size32_n_o |-> !size16_n_o); // R4
  AST_DIAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_diag_i |-> sel_fb_n_o); // R11

endmodule

// File: tb/tb_chan_slave_front.sv
module tb_chan_slave_front;
  localparam int AW = 32, BB = 4, DF = 12, WS = 3;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr_i = '0;
  logic mio_i = 0, addr24_n_i = 1, refresh_n_i = 1, s0_n_i = 1, s1_n_i = 1, adl_n_i = 1, cmd_n_i = 1;
  logic [AW-BB-1:0] cfg_base_i = 28'h0001234;
  logic [1:0] cfg_width_i = 2'd1;
  logic cfg_diag_i = 0;
  logic sel_fb_n_o, size16_n_o, size32_n_o, ready_o, reg_rd_o, reg_wr_o, rd_oe_o;
  logic [BB-1:0] reg_addr_o;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  chan_slave_front dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_hit(input logic [AW-1:0] a, input logic m, input logic a24n,
                                 input logic refn, input logic [AW-BB-1:0] base);
    logic [AW-1:0] e;
    e = a24n ? a : {8'h00, a[23:0]};
    if (!m) return 0;
    if (e[AW-1:BB] != base) return 0;
    if (!refn && e[BB-1:0] >= DF) return 0;
    return 1;
  endfunction

  function automatic logic [2:0] exp_fb(input bit h, input logic [1:0] w, input logic dg);
    exp_fb[2] = !(h && !dg);
    exp_fb[1] = !(h && w != 0);
    exp_fb[0] = !(h && w >= 2);
  endfunction

  task automatic fb(input string req, input logic [AW-1:0] a, input logic m, input logic a24n,
                    input logic refn, input logic [1:0] w, input logic dg);
    logic [2:0] e;
    @(negedge clk);
    addr_i = a; mio_i = m; addr24_n_i = a24n; refresh_n_i = refn; cfg_width_i = w; cfg_diag_i = dg;
    #1;
    e = exp_fb(exp_hit(a, m, a24n, refn, cfg_base_i), w, dg);
    chk({sel_fb_n_o, size16_n_o, size32_n_o} == e, req, {sel_fb_n_o, size16_n_o, size32_n_o}, e);
  endtask

  task automatic cycle(input logic [AW-1:0] a, input bit wr);
    @(negedge clk);
    addr_i = a; mio_i = 1; addr24_n_i = 1; refresh_n_i = 1; cfg_diag_i = 0;
    s0_n_i = !wr; s1_n_i = wr; adl_n_i = 0;
    #1 chk(ready_o == 0, "R8 ready low on decode+status", ready_o, 0);
    @(negedge clk);
    @(negedge clk);
    #1 chk(ready_o == 0, "R8 ready still low after WS-1 edges", ready_o, 0);
    @(negedge clk);
    adl_n_i = 1;
    #1 chk(ready_o == 1, "R8 ready high after WS edges", ready_o, 1);
    @(negedge clk);
    cmd_n_i = 0;
    #1;
    chk(reg_addr_o == a[BB-1:0], "R7 captured offset", reg_addr_o, a[BB-1:0]);
    chk(reg_wr_o == wr, "R9 write pulse at command lead", reg_wr_o, wr);
    chk(reg_rd_o == !wr, "R10 read enable under command", reg_rd_o, !wr);
    addr_i = a ^ 32'h5; s0_n_i = 1; s1_n_i = 1;
    @(negedge clk);
    #1;
    chk(reg_wr_o == 0, "R9 write pulse one cycle", reg_wr_o, 0);
    chk(reg_addr_o == a[BB-1:0], "R7 offset held during command", reg_addr_o, a[BB-1:0]);
    chk(reg_rd_o == !wr, "R10 read enable held", reg_rd_o, !wr);
    @(negedge clk);
    cmd_n_i = 1;
    #1;
    chk(reg_rd_o == 0, "R10 read enable off", reg_rd_o, 0);
    chk(rd_oe_o == !wr, "R10 output enable extends", rd_oe_o, !wr);
    @(negedge clk);
    #1 chk(rd_oe_o == 0, "R10 output enable ends", rd_oe_o, 0);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] base_a;
    void'($urandom(32'h51AC));
    base_a = {cfg_base_i, 4'h0};
    repeat (3) @(negedge clk);
    #1;
    chk({sel_fb_n_o, size16_n_o, size32_n_o} == 3'b111, "R3 reset feedback idle", {sel_fb_n_o, size16_n_o, size32_n_o}, 3'b111);
    chk(ready_o == 1 && reg_wr_o == 0 && reg_rd_o == 0 && rd_oe_o == 0, "R8 reset strobes idle",
        {ready_o, reg_wr_o, reg_rd_o, rd_oe_o}, 4'b1000);
    rst_n = 1;

    fb("R1 R3 memory hit 16-bit", base_a | 32'h3, 1, 1, 1, 2'd1, 0);
    fb("R1 io cycle misses", base_a | 32'h3, 0, 1, 1, 2'd1, 0);
    fb("R4 8-bit port", base_a | 32'h1, 1, 1, 1, 2'd0, 0);
    fb("R4 32-bit port", base_a | 32'h1, 1, 1, 1, 2'd2, 0);
    fb("R4 code 3 as 32-bit", base_a | 32'h1, 1, 1, 1, 2'd3, 0);
    fb("R5 decode lost", base_a + 32'h10, 1, 1, 1, 2'd2, 0);
    fb("R2 low-address mode drops upper bits", base_a | 32'h7300_0002, 1, 0, 1, 2'd1, 0);
    fb("R2 full address misses with upper bits", base_a | 32'h7300_0002, 1, 1, 1, 2'd1, 0);
    cfg_base_i = 28'h1001234;
    fb("R2 window above 16MB hits", 32'h1001_2345, 1, 1, 1, 2'd1, 0);
    fb("R2 window above 16MB misses in low mode", 32'h1001_2345, 1, 0, 1, 2'd1, 0);
    cfg_base_i = 28'h0001234;
    fb("R6 destructive offset blocked in refresh", base_a | 32'hD, 1, 1, 0, 2'd1, 0);
    fb("R6 edge offset DF blocked in refresh", base_a | 32'hC, 1, 1, 0, 2'd1, 0);
    fb("R6 safe offset decodes in refresh", base_a | 32'hB, 1, 1, 0, 2'd1, 0);
    fb("R6 destructive offset decodes without refresh", base_a | 32'hD, 1, 1, 1, 2'd1, 0);
    fb("R11 diagnostic quiet acknowledge", base_a | 32'h2, 1, 1, 1, 2'd1, 1);

    cycle(base_a | 32'h6, 1);
    cycle(base_a | 32'h9, 0);

    @(negedge clk);
    addr_i = base_a + 32'h40; mio_i = 1; s0_n_i = 0;
    #1 chk(ready_o == 1, "R8 no stretch without decode", ready_o, 1);
    s0_n_i = 1;

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = $urandom_range(0, 1) ? (base_a | 32'($urandom_range(0, 15))) : {8'h00, 24'($urandom)};
      if ($urandom_range(0, 3) == 0) a[31:24] = 8'($urandom);
      fb("R1 R2 R3 R4 R6 R11 random", a, 1'($urandom), 1'($urandom), 1'($urandom),
         2'($urandom), 1'($urandom_range(0, 4) == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule